// File: doc/BRIEF.md
# Packed SIMD Lane Shift Unit

This unit shifts a 64-bit operand as a group of independent packed lanes of 8, 16 or 32 bits. Three operations are available: left shift, logical right shift and arithmetic right shift. A single shift count, taken from the low bits of the second operand, applies to every lane. No bit ever crosses from one lane into another.

The result is computed combinationally and captured in one register stage when the input valid strobe is high. A matching output valid strobe appears one cycle later. A pipeline in an execution cluster uses the unit by presenting both operands with a lane-size code and an operation code.

Top module: `lane_shift_unit`

## Requirements
- R1: After a synchronous active-high reset, `resOut` is zero and `resValid` is low.
- R2: `resValid` equals `inValid` delayed by one cycle. `resOut` is updated only on a cycle where `inValid` is high, and otherwise it keeps its value.
- R3: Lane-size code `laneSel`: 2'b00 selects eight 8-bit lanes with count `opB[2:0]`. 2'b01 selects four 16-bit lanes with count `opB[3:0]`. 2'b10 selects two 32-bit lanes with count `opB[4:0]`. All higher bits of `opB` are ignored.
- R4: Operation code `opSel` 2'b00 is a left shift. Bits that leave the top of a lane are dropped, and the vacated low bits are zero.
- R5: Operation code `opSel` 2'b01 is a logical right shift. Bits that leave the bottom of a lane are dropped, and the vacated high bits are zero.
- R6: Operation code `opSel` 2'b10 is an arithmetic right shift. Each lane's own sign bit (its top bit) fills its vacated high bits.
- R7: Each lane result occupies the same bit positions as its source lane.
- R8: If `laneSel` is 2'b11 or `opSel` is 2'b11, the registered result is zero.
- R9: A shift count of zero returns `opA` unchanged for every valid operation and lane size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input operands valid |
| opA | input | 64 | Packed operand to shift |
| opB | input | 64 | Shift count source (low bits) |
| laneSel | input | 2 | Lane size code |
| opSel | input | 2 | Operation code |
| resValid | output | 1 | Result valid, one cycle after inValid |
| resOut | output | 64 | Registered shifted result |

## Verification
The main function is driven with lane patterns whose top bits are set and with patterns whose top bits are clear. This separates arithmetic from logical right shifts, and it shows whether a sign bit leaks from the wrong lane. Counts of zero, one and the lane maximum are used, with junk in the upper bits of `opB`, to confirm that each lane width masks the count correctly. Alternating-bit words show whether shifted bits spill across a lane boundary. A randomized sweep over every code, including the reserved ones, is compared against a lane-by-lane reference model.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;
  localparam int DataW = 64;

  typedef enum logic [1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10,
    LANERS = 2'b11
  } laneSize_e;

  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHRU = 2'b01,
    OP_SHRS = 2'b10,
    OP_RSV  = 2'b11
  } shiftOp_e;

  typedef struct packed {
    logic capture;
    logic zeroOut;
    logic [2:0] laneOneHot;
  } shiftCtrl_t;
endpackage

// File: rtl/lane_shift_ctrl.sv
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] laneSel,
  input  logic [1:0] opSel,
  output shiftCtrl_t ctrl
);
  always_comb begin
    ctrl.capture = inValid;
    ctrl.laneOneHot = 3'b000;
    unique case (laneSize_e'(laneSel))
      LANE8:   ctrl.laneOneHot = 3'b001;
      LANE16:  ctrl.laneOneHot = 3'b010;
      LANE32:  ctrl.laneOneHot = 3'b100;
      default: ctrl.laneOneHot = 3'b000;
    endcase
    ctrl.zeroOut = (laneSize_e'(laneSel) == LANERS) || (shiftOp_e'(opSel) == OP_RSV);
  end
endmodule

// File: rtl/lane_shift_dp.sv
module lane_shift_dp
  import lane_shift_pkg::*;
#(
  parameter int DataWidth = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  shiftCtrl_t           ctrl,
  input  logic [DataWidth-1:0] opA,
  input  logic [DataWidth-1:0] opB,
  input  logic [1:0]           opSel,
  output logic [DataWidth-1:0] resOut
);
  localparam int NumSizes = 3;

  logic [DataWidth-1:0] sizeRes [NumSizes];
  logic [DataWidth-1:0] nextRes;

  for (genvar s = 0; s < NumSizes; s++) begin : g_size
    localparam int LaneW  = 8 << s;
    localparam int CntW   = $clog2(LaneW);
    localparam int NLanes = DataWidth / LaneW;
    logic [CntW-1:0] cnt;
    assign cnt = opB[CntW-1:0];
    for (genvar l = 0; l < NLanes; l++) begin : g_lane
      logic [LaneW-1:0] src;
      logic [LaneW-1:0] dst;
      assign src = opA[l*LaneW +: LaneW];
      always_comb begin
        unique case (shiftOp_e'(opSel))
          OP_SHL:  dst = src << cnt;
          OP_SHRU: dst = src >> cnt;
          OP_SHRS: dst = LaneW'($signed(src) >>> cnt);
          default: dst = '0;
        endcase
      end
      assign sizeRes[s][l*LaneW +: LaneW] = dst;
    end
  end

  always_comb begin
    nextRes = '0;
    for (int s = 0; s < NumSizes; s++)
      if (ctrl.laneOneHot[s]) nextRes = sizeRes[s];
    if (ctrl.zeroOut) nextRes = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) resOut <= '0;
    else if (ctrl.capture) resOut <= nextRes;
  end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
  import lane_shift_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [1:0]  laneSel,
  input  logic [1:0]  opSel,
  output logic        resValid,
  output logic [63:0] resOut
);
  shiftCtrl_t ctrl;

  lane_shift_ctrl ctrl_i (
    .inValid(inValid), .laneSel(laneSel), .opSel(opSel), .ctrl(ctrl)
  );

  lane_shift_dp #(.DataWidth(DataW)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .opA(opA), .opB(opB),
    .opSel(opSel), .resOut(resOut)
  );

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= inValid;
  end
endmodule

// File: rtl/lane_shift_checker.sv
module lane_shift_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [1:0]  laneSel,
  input logic [1:0]  opSel,
  input logic        resValid,
  input logic [63:0] resOut
);
  logic pastOk;
  always_ff @(posedge clk) pastOk <= !rst;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (resOut == '0 && !resValid));

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    pastOk |-> (resValid == $past(inValid)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !inValid) |=> $stable(resOut));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && (laneSel == 2'b11 || opSel == 2'b11)) |=> (resOut == '0));

  p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSel != 2'b11 && opSel != 2'b11 && opB[4:0] == 5'd0) |=> (resOut == $past(opA)));

  p_shl_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && laneSel == 2'b00 && opSel == 2'b00 && opB[2:0] != 3'd0) |=>
      (resOut[0] == 1'b0 && resOut[8] == 1'b0));
endmodule

bind lane_shift_unit lane_shift_checker chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
  .laneSel(laneSel), .opSel(opSel), .resValid(resValid), .resOut(resOut)
);

// File: tb/lane_shift_unit_tb_top.sv
module lane_shift_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0] laneSel = '0, opSel = '0;
  logic resValid;
  logic [63:0] resOut;

  int tests = 0;
  int fails = 0;
  logic [63:0] expQ [$];
  string tagQ [$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_shift_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .laneSel(laneSel), .opSel(opSel), .resValid(resValid), .resOut(resOut)
  );

  function automatic logic [63:0] refModel(logic [63:0] a, logic [63:0] b,
                                           logic [1:0] ls, logic [1:0] op);
    logic [63:0] r;
    int w, c;
    r = '0;
    if (ls == 2'b11 || op == 2'b11) return '0;
    w = 8 << ls;
    c = int'(b) & (w - 1);
    for (int l = 0; l < 64 / w; l++) begin
      longint v;
      logic [63:0] u;
      u = '0;
      for (int k = 0; k < w; k++) u[k] = a[l*w + k];
      if (op == 2'b00) u = u << c;
      else if (op == 2'b01) u = u >> c;
      else begin
        if (u[w-1]) for (int k = w; k < 64; k++) u[k] = 1'b1;
        v = longint'(u);
        v = v >>> c;
        u = 64'(v);
      end
      for (int k = 0; k < w; k++) r[l*w + k] = u[k];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [1:0] ls,
                       logic [1:0] op, string tag, logic [63:0] exp);
    @(negedge clk);
    opA = a; opB = b; laneSel = ls; opSel = op; inValid = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic driveRef(logic [63:0] a, logic [63:0] b, logic [1:0] ls,
                          logic [1:0] op, string tag);
    drive(a, b, ls, op, tag, refModel(a, b, ls, op));
  endtask

  // monitor: sample away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && resValid) begin
        if (expQ.size() == 0) check("R2 spurious valid", 64'd1, 64'd0);
        else check(tagQ.pop_front(), resOut, expQ.pop_front());
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset resOut", resOut, 64'd0);
    check("R1 reset resValid", {63'd0, resValid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R4 / R7 hand-computed
    drive(64'h8181_8181_8181_8181, 64'hFFF8, 2'b00, 2'b00, "R4 R3 shl8 cnt0 masked", 64'h8181_8181_8181_8181);
    drive(64'h8181_8181_8181_8181, 64'h1, 2'b00, 2'b00, "R4 R7 shl8 by1", 64'h0202_0202_0202_0202);
    drive(64'h8001_8001_8001_8001, 64'h1, 2'b01, 2'b01, "R5 shru16 by1", 64'h4000_4000_4000_4000);
    drive(64'h8000_0001_7FFF_FFFE, 64'h1F, 2'b10, 2'b10, "R6 shrs32 by31", 64'hFFFF_FFFF_0000_0000);
    drive(64'h8000_7FFF_8000_7FFF, 64'hF, 2'b01, 2'b10, "R6 shrs16 by15", 64'hFFFF_0000_FFFF_0000);
    drive(64'h8000_7FFF_8000_7FFF, 64'h13, 2'b01, 2'b01, "R3 shru16 cnt masked to 3", 64'h1000_0FFF_1000_0FFF);
    drive(64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFE4, 2'b10, 2'b00, "R3 shl32 cnt 4", 64'hAAAA_AAA0_5555_5550);
    drive(64'h8080_8080_8080_8080, 64'h7, 2'b00, 2'b10, "R6 R7 shrs8 by7", 64'hFFFF_FFFF_FFFF_FFFF);
    drive(64'h8080_8080_8080_8080, 64'h7, 2'b00, 2'b01, "R5 R7 shru8 by7", 64'h0101_0101_0101_0101);
    drive(64'h1234_5678_9ABC_DEF0, 64'h0, 2'b11, 2'b00, "R8 reserved lane", 64'h0);
    drive(64'h1234_5678_9ABC_DEF0, 64'h0, 2'b01, 2'b11, "R8 reserved op", 64'h0);
    drive(64'hF234_5678_9ABC_DEF0, 64'h20, 2'b10, 2'b10, "R9 zero count shrs32", 64'hF234_5678_9ABC_DEF0);
    drive(64'hF234_5678_9ABC_DEF0, 64'h10, 2'b01, 2'b00, "R9 zero count shl16", 64'hF234_5678_9ABC_DEF0);

    // R2 hold: no valid, change inputs, output stays
    @(negedge clk);
    opA = 64'hDEAD; opB = 64'h1; laneSel = 2'b00; opSel = 2'b00;
    repeat (2) @(negedge clk);
    check("R2 hold without inValid", resOut, 64'hF234_5678_9ABC_DEF0);
    check("R2 no valid pulse", {63'd0, resValid}, 64'd0);

    // random sweep against reference
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      driveRef(a, b, 2'($urandom), 2'($urandom), "R3 R4 R5 R6 R7 random");
    end
    repeat (3) @(negedge clk);
    check("R2 queue drained", 64'(expQ.size()), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule